// File: doc/BRIEF.md
# Pointer-Rotating RAM Delay Line

This block delays a data word by a fixed number of shift steps without ever moving the stored data. The words sit in a small two-port RAM array. On each enabled cycle the incoming word goes into the entry under a write pointer, and the entry under a read pointer is captured into an output register. Both pointers then step forward and wrap around the array. The result behaves like a cascade of `DEPTH` registers, each `WIDTH` bits wide, but uses far fewer flip-flops.

There is no address input. A user supplies a shift enable and a data word. The output shows the word that was applied `DEPTH` enabled cycles earlier. The RAM is not cleared at reset. Instead, a fill tracker forces the output to zero until `DEPTH` shifts have taken place since reset. This makes the block look exactly like a shift register that was cleared to zero.

Top module: `ramsr_delay`

## Requirements
- R1: After the rising edge that completes enabled shift number s (counted from 1 since reset), with s >= DEPTH, `dout` equals the `din` value applied on enabled shift number s-DEPTH+1. This is a delay of exactly DEPTH enabled cycles.
- R2: A synchronous reset (`rst` high at a rising edge) puts the read pointer at entry 0 and the write pointer at entry DEPTH-1. It also drives `dout` to all zeros on the next cycle.
- R3: Both pointers wrap modulo DEPTH and stay in the range 0..DEPTH-1. The write pointer is always DEPTH-1 entries ahead of the read pointer, counted modulo DEPTH.
- R4: Each enabled cycle writes exactly one RAM entry and reads exactly one other entry. The read and write addresses are never equal on a shift. The delay stays exact across many full laps of the pointers.
- R5: While `shift_en` is low, the pointers, the RAM contents, the fill state and `dout` all hold their values. `din` has no effect.
- R6: After reset, `dout` reads as all zeros until DEPTH enabled shifts have completed. From shift DEPTH onward it shows stored data.
- R7: `rst` takes priority over `shift_en`. A shift requested while reset is high is discarded, and the delay count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Advances the delay line by one step when high |
| din | input | WIDTH | Word entering the delay line |
| dout | output | WIDTH | Word leaving the delay line (registered) |

## Verification
The output is registered. A change in `dout` caused by a shift shows up right after the rising edge on which `shift_en` was sampled high, and the bench samples it at the following falling edge. The word applied on an enabled edge is due on `dout` right after the DEPTH-th enabled edge, counting that one. Idle cycles do not count toward this delay.

The bench keeps its own history of accepted words and its own count of shifts since reset. It does not count edges where `rst` was high. From these it computes the value due on every falling edge: zero before DEPTH shifts, otherwise the stored history entry. Reset is checked on the falling edge that follows the reset edge.

// File: rtl/ramsr_pkg.sv
package ramsr_pkg;

  // Advance a ring index by one, wrapping at n.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // Distance from 'behind' forward to 'ahead' on a ring of n entries.
  function automatic int unsigned ring_gap(input int unsigned ahead, input int unsigned behind,
                                           input int unsigned n);
    return (ahead >= behind) ? ahead - behind : ahead + n - behind;
  endfunction

endpackage

// File: rtl/ramsr_ptr.sv
module ramsr_ptr #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr
);
  import ramsr_pkg::*;

  localparam logic [AW-1:0] RD_INIT = '0;
  localparam logic [AW-1:0] WR_INIT = AW'(DEPTH - 1);

  logic [AW-1:0] rd_nxt;
  logic [AW-1:0] wr_nxt;

  always_comb begin
    rd_nxt = AW'(ring_next(32'(rd_ptr), DEPTH));
    wr_nxt = AW'(ring_next(32'(wr_ptr), DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= RD_INIT;
      wr_ptr <= WR_INIT;
    end else if (step) begin
      rd_ptr <= rd_nxt;
      wr_ptr <= wr_nxt;
    end
  end

  AST_PTR_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_ptr == RD_INIT && wr_ptr == WR_INIT)); // R2
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_ptr) < DEPTH) && (32'(wr_ptr) < DEPTH)); // R3
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (rst)
    ring_gap(32'(wr_ptr), 32'(rd_ptr), DEPTH) == DEPTH - 1); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(rd_ptr) && $stable(wr_ptr))); // R5

endmodule

// File: rtl/ramsr_mem.sv
module ramsr_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [AW-1:0]    wr_addr,
  input  logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_word
);

  logic [WIDTH-1:0] store [DEPTH];

  // Storage array: no reset, written only on a shift.
  always_ff @(posedge clk) begin
    if (step && !rst) begin
      store[wr_addr] <= wr_data;
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word <= '0;
    end else if (step) begin
      rd_word <= store[rd_addr];
    end
  end

  AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    step |-> (rd_addr != wr_addr)); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(rd_word)); // R5

endmodule

// File: rtl/ramsr_fill.sv
module ramsr_fill #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic primed
);

  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] fill_cnt;
  logic          fill_done;

  assign fill_done = step && !primed && (fill_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
      primed   <= 1'b0;
    end else if (step && !primed) begin
      if (fill_done) primed <= 1'b1;
      else           fill_cnt <= fill_cnt + 1'b1;
    end
  end

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !primed) |=> (primed || fill_cnt == $past(fill_cnt) + 1'b1)); // R6
  AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (rst)
    primed |=> primed); // R6
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(fill_cnt) && $stable(primed))); // R5

endmodule

// File: rtl/ramsr_delay.sv
module ramsr_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    rd_ptr;
  logic [AW-1:0]    wr_ptr;
  logic [WIDTH-1:0] rd_word;
  logic             primed;
  logic             step;

  // Reset wins over a shift request (R7).
  assign step = shift_en && !rst;

  ramsr_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .rd_ptr (rd_ptr),
    .wr_ptr (wr_ptr)
  );

  ramsr_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .wr_addr (wr_ptr),
    .rd_addr (rd_ptr),
    .wr_data (din),
    .rd_word (rd_word)
  );

  ramsr_fill #(.DEPTH(DEPTH), .CW(AW)) u_fill (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .primed (primed)
  );

  // Stale RAM contents are hidden until the line has been filled once.
  assign dout = primed ? rd_word : '0;

  AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(dout)); // R5
  AST_DOUT_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == '0)); // R2

endmodule

// File: tb/test_ramsr_delay.sv
module test_ramsr_delay;
  localparam int W    = 8;
  localparam int N    = 256;
  localparam int HMAX = 8192;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;

  int checks = 0;
  int fails  = 0;
  int nshift = 0;
  logic [W-1:0] hist [HMAX];
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  ramsr_delay #(.WIDTH(W), .DEPTH(N)) i_ramsr_delay (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(din), .dout(dout)
  );

  // Value due on dout after s shifts since reset.
  function automatic logic [W-1:0] due(input int s);
    if (s < N) return '0;
    return hist[s - N];
  endfunction

  task automatic check(input string tag);
    logic [W-1:0] exp_v;
    exp_v = due(nshift);
    checks++;
    if (dout !== exp_v) begin
      fails++;
      $display("FAIL %s shift=%0d dout=%h expected=%h", tag, nshift, dout, exp_v);
    end
  endtask

  // Called at a falling edge; applies one cycle of stimulus and checks.
  task automatic step(input logic en, input logic [W-1:0] d, input string tag);
    shift_en = en;
    din      = d;
    @(posedge clk);
    #1;
    if (rst) nshift = 0;
    else if (en && nshift < HMAX) begin
      hist[nshift] = d;
      nshift++;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(input int cycles, input logic en_during);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) step(en_during, W'($urandom), "R7");
    rst = 1'b0;
    nshift = 0;
    check("R2");
  endtask

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    do_reset(3, 1'b0);

    // Fill from empty: zeros until N shifts, then exact delay.
    for (int i = 0; i < N + 40; i++)
      step(1'b1, W'(i * 7 + 3), (i < N) ? "R6" : "R1");

    // Idle gap: nothing moves, din ignored.
    for (int i = 0; i < 20; i++) step(1'b0, W'($urandom), "R5");

    // Random enable and data across several pointer laps.
    for (int i = 0; i < 1800; i++)
      step(($urandom_range(0, 9) < 7), W'($urandom), (i < 900) ? "R1" : "R4");

    // Reset while shifting is requested: the request must be discarded.
    do_reset(2, 1'b1);
    for (int i = 0; i < N + 5; i++) step(1'b1, W'($urandom), "R6");

    // Alternating bursts and idles across wrap boundaries.
    for (int i = 0; i < 900; i++)
      step((i % 5) != 4, W'($urandom), "R3");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule